// File: doc/BRIEF.md
# Quad Wiper Register Bank

This block holds the position state of four digital potentiometer channels. Every channel owns a 6-bit wiper register, whose value picks one of 64 tap points along a string of 63 resistive segments, and four 6-bit preset registers. A registered decoder in each channel turns the wiper value into a strictly one-hot enable for the 64 tap switches. The decoder never enables two taps of one channel at the same time, even for a moment.

A host drives a single-cycle command port. Each command carries an opcode, a channel index, a preset slot index and a 6-bit value. The host can load a wiper directly, store a preset, recall a preset into the wiper, or read back a channel. A read returns both the wiper and the chosen preset one cycle later. The preset registers are ordinary flops. Each preset store raises a one-cycle write strobe, which an external non-volatile busy timer can count from.

Top module: `wpr_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every wiper and every preset register clears to 0. After that edge, each channel's tap group shows only bit 0 set, and `rd_valid` and `nv_wr_strobe` are 0.
- R2: At every clock edge after reset, each channel's 64-bit tap group has exactly one bit set.
- R3: Channel c's taps occupy `taps[c*64 +: 64]`. The set bit is at index equal to that channel's wiper value, and the taps change on the same edge as the wiper.
- R4: Opcode 2'b01 (load wiper) with `cmd_valid` high writes `cmd_data` into the wiper of channel `cmd_ch` at the next edge. No other wiper or preset changes.
- R5: Opcode 2'b10 (store preset) writes `cmd_data` into preset slot `cmd_slot` of channel `cmd_ch`. The wiper and all other presets keep their values.
- R6: Opcode 2'b11 (recall) copies preset slot `cmd_slot` of channel `cmd_ch` into that channel's wiper. The preset itself is unchanged, and `cmd_data` is ignored.
- R7: Opcode 2'b00 (read) raises `rd_valid` for exactly one cycle after the command edge. In that cycle, `rd_wiper` carries the channel's wiper and `rd_data` carries preset `cmd_slot`. A read changes no register.
- R8: `nv_wr_strobe` is high for the one cycle after a store-preset command edge, and low at all other times.
- R9: While `cmd_valid` is low, no register, tap, strobe or read output changes state, whatever the other command inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 00 read, 01 load wiper, 10 store preset, 11 recall |
| cmd_ch | input | 2 | Channel index |
| cmd_slot | input | 2 | Preset slot index |
| cmd_data | input | 6 | Value for load wiper or store preset |
| rd_valid | output | 1 | Read result valid |
| rd_wiper | output | 6 | Wiper value of the read channel |
| rd_data | output | 6 | Preset value of the read slot |
| nv_wr_strobe | output | 1 | One-cycle pulse after each preset store |
| taps | output | 256 | One-hot tap enables, 64 per channel |

## Verification
The bench drives wiper values 0 and 63, the two ends of the decoder. A decoder with an off-by-one or a truncated shift would light the wrong tap, or no tap, at those values. It issues back-to-back commands to different channels and slots, such as a recall directly after a store to the same slot. A design that let the channel or slot index leak into a neighbour would corrupt registers that the bench later reads back. It also holds `cmd_valid` low while placing active opcodes on the port, so a design that ignored the valid bit would move taps or pulse the strobe. Finally, it checks that a recall leaves the preset intact and ignores `cmd_data`, which catches a design that swapped the copy direction or loaded the command value instead.

// File: rtl/wpr_pkg.sv
package wpr_pkg;

    localparam int NUM_CH     = 4;
    localparam int NUM_SLOT   = 4;
    localparam int POS_W      = 6;
    localparam int NUM_TAPS   = 1 << POS_W;
    localparam int CH_IDX_W   = $clog2(NUM_CH);
    localparam int SLOT_IDX_W = $clog2(NUM_SLOT);
    localparam int TAPS_ALL_W = NUM_CH * NUM_TAPS;

    typedef enum logic [1:0] {
        OP_READ   = 2'b00,
        OP_LOAD   = 2'b01,
        OP_STORE  = 2'b10,
        OP_RECALL = 2'b11
    } op_e;

    typedef logic [POS_W-1:0]      pos_t;
    typedef logic [NUM_TAPS-1:0]   tap_vec_t;
    typedef logic [SLOT_IDX_W-1:0] slot_t;

    typedef struct packed {
        logic  load;
        logic  store;
        logic  recall;
        slot_t slot;
        pos_t  value;
    } ch_ctl_t;

    function automatic tap_vec_t pos_to_tap(input pos_t p);
        tap_vec_t v;
        for (int i = 0; i < NUM_TAPS; i++) begin
            v[i] = (pos_t'(i) == p);
        end
        return v;
    endfunction

endpackage

// File: rtl/wpr_cmd_decode.sv
module wpr_cmd_decode
    import wpr_pkg::*;
(
    input  logic                  cmd_valid,
    input  logic [1:0]            cmd_op,
    input  logic [CH_IDX_W-1:0]   cmd_ch,
    input  logic [SLOT_IDX_W-1:0] cmd_slot,
    input  logic [POS_W-1:0]      cmd_data,
    output ch_ctl_t               ctl [NUM_CH],
    output logic                  rd_req,
    output logic                  store_req
);

    op_e op;
    assign op = op_e'(cmd_op);

    assign rd_req    = cmd_valid && (op == OP_READ);
    assign store_req = cmd_valid && (op == OP_STORE);

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ctl
            logic hit;
            assign hit = cmd_valid && (cmd_ch == CH_IDX_W'(c));
            always_comb begin
                ctl[c].load   = hit && (op == OP_LOAD);
                ctl[c].store  = hit && (op == OP_STORE);
                ctl[c].recall = hit && (op == OP_RECALL);
                ctl[c].slot   = cmd_slot;
                ctl[c].value  = cmd_data;
            end
        end
    endgenerate

endmodule

// File: rtl/wpr_tap_decoder.sv
module wpr_tap_decoder
    import wpr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pos_t     pos_next,
    output tap_vec_t tap
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tap <= pos_to_tap('0);
        end else begin
            tap <= pos_to_tap(pos_next);
        end
    end

    assert_tap_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $countones(tap) == 1);

endmodule

// File: rtl/wpr_channel.sv
module wpr_channel
    import wpr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ch_ctl_t  ctl,
    output pos_t     wiper,
    output pos_t     slot_q [NUM_SLOT],
    output tap_vec_t tap
);

    pos_t wiper_d;

    always_comb begin
        wiper_d = wiper;
        if (ctl.load) begin
            wiper_d = ctl.value;
        end else if (ctl.recall) begin
            wiper_d = slot_q[ctl.slot];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wiper <= '0;
        end else begin
            wiper <= wiper_d;
        end
    end

    generate
        for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    slot_q[s] <= '0;
                end else if (ctl.store && ctl.slot == SLOT_IDX_W'(s)) begin
                    slot_q[s] <= ctl.value;
                end
            end
        end
    endgenerate

    wpr_tap_decoder u_dec (
        .clk      (clk),
        .rst      (rst),
        .pos_next (wiper_d),
        .tap      (tap)
    );

    assert_tap_tracks_wiper_R3: assert property (@(posedge clk) disable iff (rst)
        tap[wiper] == 1'b1);

    assert_load_wiper_R4: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> wiper == $past(ctl.value));

    assert_recall_copy_R6: assert property (@(posedge clk) disable iff (rst)
        ctl.recall |=> wiper == $past(slot_q[ctl.slot]));

    assert_store_keeps_wiper_R5: assert property (@(posedge clk) disable iff (rst)
        (ctl.store && !ctl.load && !ctl.recall) |=> $stable(wiper));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!ctl.load && !ctl.recall) |=> $stable(wiper));

endmodule

// File: rtl/wpr_bank.sv
module wpr_bank
    import wpr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_valid,
    input  logic [1:0]            cmd_op,
    input  logic [CH_IDX_W-1:0]   cmd_ch,
    input  logic [SLOT_IDX_W-1:0] cmd_slot,
    input  logic [POS_W-1:0]      cmd_data,
    output logic                  rd_valid,
    output logic [POS_W-1:0]      rd_wiper,
    output logic [POS_W-1:0]      rd_data,
    output logic                  nv_wr_strobe,
    output logic [TAPS_ALL_W-1:0] taps
);

    ch_ctl_t  ctl      [NUM_CH];
    pos_t     wiper_all[NUM_CH];
    pos_t     slot_all [NUM_CH][NUM_SLOT];
    tap_vec_t tap_all  [NUM_CH];
    logic     rd_req;
    logic     store_req;

    wpr_cmd_decode u_decode (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_ch    (cmd_ch),
        .cmd_slot  (cmd_slot),
        .cmd_data  (cmd_data),
        .ctl       (ctl),
        .rd_req    (rd_req),
        .store_req (store_req)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            wpr_channel u_ch (
                .clk    (clk),
                .rst    (rst),
                .ctl    (ctl[c]),
                .wiper  (wiper_all[c]),
                .slot_q (slot_all[c]),
                .tap    (tap_all[c])
            );
            assign taps[c*NUM_TAPS +: NUM_TAPS] = tap_all[c];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid     <= 1'b0;
            rd_wiper     <= '0;
            rd_data      <= '0;
            nv_wr_strobe <= 1'b0;
        end else begin
            rd_valid     <= rd_req;
            nv_wr_strobe <= store_req;
            if (rd_req) begin
                rd_wiper <= wiper_all[cmd_ch];
                rd_data  <= slot_all[cmd_ch][cmd_slot];
            end
        end
    end

    assert_strobe_after_store_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'b10) |=> nv_wr_strobe);

    assert_strobe_only_store_R8: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && cmd_op == 2'b10) |=> !nv_wr_strobe);

    assert_read_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'b00) |=> rd_valid);

    assert_idle_no_read_R9: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> (!rd_valid && !nv_wr_strobe));

endmodule

// File: tb/wpr_bank_test.sv
module wpr_bank_test;
    import wpr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic                  clk = 1'b0;
    logic                  rst;
    logic                  cmd_valid;
    logic [1:0]            cmd_op;
    logic [CH_IDX_W-1:0]   cmd_ch;
    logic [SLOT_IDX_W-1:0] cmd_slot;
    logic [POS_W-1:0]      cmd_data;
    logic                  rd_valid;
    logic [POS_W-1:0]      rd_wiper;
    logic [POS_W-1:0]      rd_data;
    logic                  nv_wr_strobe;
    logic [TAPS_ALL_W-1:0] taps;

    wpr_bank uut (
        .clk (clk), .rst (rst), .cmd_valid (cmd_valid), .cmd_op (cmd_op),
        .cmd_ch (cmd_ch), .cmd_slot (cmd_slot), .cmd_data (cmd_data),
        .rd_valid (rd_valid), .rd_wiper (rd_wiper), .rd_data (rd_data),
        .nv_wr_strobe (nv_wr_strobe), .taps (taps)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int n_reads  = 0;

    logic [POS_W-1:0] m_wiper [NUM_CH];
    logic [POS_W-1:0] m_slot  [NUM_CH][NUM_SLOT];
    logic [2*POS_W-1:0] exp_q[$];

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_taps(input string req);
        for (int c = 0; c < NUM_CH; c++) begin
            logic [NUM_TAPS-1:0] got;
            logic [NUM_TAPS-1:0] want;
            got  = taps[c*NUM_TAPS +: NUM_TAPS];
            want = '0;
            want[m_wiper[c]] = 1'b1;
            check(got == want && $countones(got) == 1, req,
                  longint'(got[POS_W*5-1:0]) ^ longint'(c), longint'(want[POS_W*5-1:0]) ^ longint'(c));
        end
    endtask

    // driver: called at a negedge, returns at the negedge after the command edge
    task automatic issue(input logic [1:0] op, input int ch, input int slot, input int data, input string req);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_ch    = CH_IDX_W'(ch);
        cmd_slot  = SLOT_IDX_W'(slot);
        cmd_data  = POS_W'(data);
        case (op)
            2'b00: exp_q.push_back({m_wiper[ch], m_slot[ch][slot]});
            2'b01: m_wiper[ch] = POS_W'(data);
            2'b10: m_slot[ch][slot] = POS_W'(data);
            default: m_wiper[ch] = m_slot[ch][slot];
        endcase
        @(negedge clk);
        check(nv_wr_strobe == (op == 2'b10), {req, " R8 strobe"}, longint'(nv_wr_strobe), longint'(op == 2'b10));
        check_taps({req, " R2 R3 taps"});
    endtask

    task automatic idle(input int cycles, input logic [1:0] junk_op);
        cmd_valid = 1'b0;
        cmd_op    = junk_op;
        cmd_data  = 6'h2a;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check(!nv_wr_strobe && !rd_valid, "R9 idle outputs quiet",
                  longint'({rd_valid, nv_wr_strobe}), 0);
            check_taps("R9 idle taps unchanged");
        end
    endtask

    task automatic read_all(input string req);
        for (int c = 0; c < NUM_CH; c++)
            for (int s = 0; s < NUM_SLOT; s++)
                issue(2'b00, c, s, 0, req);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // monitor: pops the scoreboard whenever a read result appears
    always @(negedge clk) begin
        if (rst === 1'b0 && rd_valid === 1'b1) begin
            n_reads++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected rd_valid", 1, 0);
            end else begin
                logic [2*POS_W-1:0] e;
                e = exp_q.pop_front();
                check({rd_wiper, rd_data} == e, "R7 read data (R4 R5 R6 contents)",
                      longint'({rd_wiper, rd_data}), longint'(e));
            end
        end
    end

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = 2'b01; cmd_ch = '0; cmd_slot = '0; cmd_data = 6'h3f;
        for (int c = 0; c < NUM_CH; c++) begin
            m_wiper[c] = '0;
            for (int s = 0; s < NUM_SLOT; s++) m_slot[c][s] = '0;
        end
        repeat (3) @(negedge clk);
        check(!rd_valid && !nv_wr_strobe, "R1 reset outputs", longint'({rd_valid, nv_wr_strobe}), 0);
        check_taps("R1 reset taps at 0");
        rst = 1'b0;
        read_all("R1 reset contents");

        // direct wiper loads including both ends
        issue(2'b01, 0, 0, 63, "R4 load ch0 top");
        issue(2'b01, 1, 0, 0,  "R4 load ch1 bottom");
        issue(2'b01, 2, 0, 33, "R4 load ch2");
        issue(2'b01, 3, 0, 1,  "R4 load ch3");
        issue(2'b01, 3, 0, 62, "R4 reload ch3");

        // store presets, back-to-back, distinct values per slot
        for (int c = 0; c < NUM_CH; c++)
            for (int s = 0; s < NUM_SLOT; s++)
                issue(2'b10, c, s, (c * 17 + s * 5 + 3) % 64, "R5 store preset");
        issue(2'b10, 2, 3, 63, "R5 store top value");
        issue(2'b10, 1, 0, 0,  "R5 store zero");
        idle(2, 2'b10);
        read_all("R5 after stores");

        // recall, with junk data that must be ignored
        issue(2'b11, 2, 3, 5,  "R6 recall 63");
        issue(2'b11, 0, 1, 9,  "R6 recall ch0");
        issue(2'b10, 3, 2, 44, "R5 store before recall");
        issue(2'b11, 3, 2, 7,  "R6 recall just stored");
        issue(2'b11, 1, 0, 31, "R6 recall zero");
        issue(2'b00, 2, 3, 0,  "R6 preset intact");
        issue(2'b00, 3, 2, 0,  "R6 preset intact 2");

        // valid low with active opcodes on the port
        idle(3, 2'b01);
        idle(3, 2'b11);
        cmd_op = 2'b00;
        idle(2, 2'b00);

        // mixed back-to-back traffic
        for (int k = 0; k < 40; k++) begin
            logic [1:0] op;
            op = 2'((k * 7 + 1) % 4);
            issue(op, (k * 3) % 4, (k * 5 + 1) % 4, (k * 13 + 11) % 64, "R4 R5 R6 R7 mixed");
        end
        idle(2, 2'b00);
        read_all("R7 final contents");
        idle(3, 2'b00);
        check(exp_q.size() == 0, "R7 all reads returned", longint'(exp_q.size()), 0);
        finish_run();
    end

endmodule